// File: doc/BRIEF.md
# Program Counter and Control State Unit

This unit holds a processor's program counter, an instruction-set mode flag, a status word and a file of 64 control registers, each 64 bits wide. A new program counter value is split as it is written. Its least significant bit becomes the mode flag and is cleared in the stored fetch address. This lets a branch target carry the instruction-set switch in its low bit.

Control register slot 0 has no storage of its own. It is a window onto the 32-bit status word: a read returns the status word padded with zeros, and a write loads the status word from the low half of the data. Six status flags can also be read and written one bit at a time through a 3-bit flag selector. All reads are combinational, and all state updates on the rising clock edge.

Top module: `pc_ctrl_state`

## Requirements
- R1: When `pc_wr_en` is high at a clock edge, `pc_q` holds `pc_wr_data` with bit 0 forced to 0 from the next cycle on, and `pc_q[0]` is always 0.
- R2: When `pc_wr_en` is high at a clock edge, `mode_q` takes `pc_wr_data[0]` from the next cycle on.
- R3: A direct mode write request (`mode_wr_en` with `mode_wr_val`) has no effect: `mode_q` changes only through a program counter write.
- R4: A write to control register index 1 to 63 stores the full 64 bits, and reading that index returns them. No other index changes.
- R5: Reading control register index 0 returns the 32-bit status word in bits 31:0, with bits 63:32 always zero.
- R6: A write to control register index 0 loads the status word from `cr_wr_data[31:0]`, discards the upper half, and changes no entry at index 1 to 63.
- R7: The flag selector codes map to status bits as follows: 0 is bit 14 (float bank), 1 is bit 13 (float transfer size), 2 is bit 12 (float precision), 3 is bit 9 (divide M), 4 is bit 8 (divide Q) and 5 is bit 1 (saturation). `flag_rd_val` returns the selected bit.
- R8: A flag write sets only its own status bit to `flag_wr_val` and keeps all other status bits.
- R9: A program counter write and a flag write in the same cycle both take effect. A control register 0 write in the same cycle as a flag write wins, and the status word then equals the written low half.
- R10: After reset the program counter, the mode flag, the status word and every control register read as zero.
- R11: Reads are combinational, and a write is not visible until after the clock edge that takes it.
- R12: Flag selector codes 6 and 7 select nothing: a flag write with them leaves the status word unchanged, and a flag read with them returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_wr_en | input | 1 | Program counter write strobe |
| pc_wr_data | input | 64 | New program counter value; bit 0 is the mode |
| pc_q | output | 64 | Current fetch address, always even |
| mode_q | output | 1 | Current instruction-set mode flag |
| mode_wr_en | input | 1 | Direct mode write request (ignored) |
| mode_wr_val | input | 1 | Value of the ignored direct mode write |
| cr_wr_en | input | 1 | Control register write strobe |
| cr_wr_idx | input | 6 | Control register write index |
| cr_wr_data | input | 64 | Control register write data |
| cr_rd_idx | input | 6 | Control register read index |
| cr_rd_data | output | 64 | Control register read data |
| flag_wr_en | input | 1 | Single-flag write strobe |
| flag_sel | input | 3 | Flag selector for writes |
| flag_wr_val | input | 1 | New flag value |
| flag_rd_sel | input | 3 | Flag selector for reads |
| flag_rd_val | output | 1 | Selected flag value |

## Verification
The assertions assume that every input carries a known 0 or 1 at each rising edge, and that all write strobes stay low while reset is held. They compare each edge's outcome with the inputs sampled one cycle earlier. The stimulus drives every input at the falling edge with defined values only, and keeps the strobes low through reset. Random traffic steers about a third of control register writes to index 0 and includes the unused selector codes, so that clashes with flag writes and invalid selectors occur often.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int SR_W = 32;
  localparam int SEL_W = 3;

  typedef logic [SR_W-1:0] sr_t;

  // one-hot mask of the status bit addressed by a flag selector; zero if none
  function automatic sr_t flag_mask(input logic [SEL_W-1:0] sel);
    sr_t m;
    m = '0;
    case (sel)
      3'd0: m[14] = 1'b1;
      3'd1: m[13] = 1'b1;
      3'd2: m[12] = 1'b1;
      3'd3: m[9]  = 1'b1;
      3'd4: m[8]  = 1'b1;
      3'd5: m[1]  = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic sr_t merge_flag(input sr_t sr, input sr_t mask, input logic v);
    return (sr & ~mask) | (v ? mask : '0);
  endfunction
endpackage

// File: rtl/pc_mode_reg.sv
module pc_mode_reg #(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_data,
  input  logic            mode_req_en,
  input  logic            mode_req_val,
  output logic [PC_W-1:0] pc_q,
  output logic            mode_q,
  output logic            mode_req_blocked
);
  function automatic logic [PC_W-1:0] fetch_addr(input logic [PC_W-1:0] v);
    return {v[PC_W-1:1], 1'b0};
  endfunction

  // a direct request that would have changed the mode, but is dropped
  assign mode_req_blocked = mode_req_en && (mode_req_val != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      pc_q   <= fetch_addr(wr_data);
      mode_q <= wr_data[0];
    end
  end
endmodule

// File: rtl/status_word.sv
module status_word
  import pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_wr_en,
  input  sr_t              full_wr_data,
  input  logic             flag_wr_en,
  input  logic [SEL_W-1:0] flag_sel,
  input  logic             flag_wr_val,
  input  logic [SEL_W-1:0] flag_rd_sel,
  output logic             flag_rd_val,
  output logic             flag_applied,
  output sr_t              sr_q
);
  sr_t wr_mask;
  sr_t rd_mask;

  assign wr_mask      = flag_mask(flag_sel);
  assign rd_mask      = flag_mask(flag_rd_sel);
  assign flag_applied = flag_wr_en && (|wr_mask) && !full_wr_en;
  assign flag_rd_val  = |(sr_q & rd_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else if (full_wr_en)
      sr_q <= full_wr_data;
    else if (flag_applied)
      sr_q <= merge_flag(sr_q, wr_mask, flag_wr_val);
  end
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g == 0) begin : g_alias
      // slot 0 is served by the status word; no flops here
      assign ent[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent[g] <= '0;
        else if (wr_en && (wr_idx == IDX_W'(g)))
          ent[g] <= wr_data;
      end
    end
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/pc_ctrl_state.sv
module pc_ctrl_state
  import pcs_pkg::*;
#(
  parameter int PC_W     = 64,
  parameter int CR_DEPTH = 64,
  parameter int CR_W     = 64,
  parameter int IDX_W    = $clog2(CR_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_wr_en,
  input  logic [PC_W-1:0]  pc_wr_data,
  output logic [PC_W-1:0]  pc_q,
  output logic             mode_q,
  input  logic             mode_wr_en,
  input  logic             mode_wr_val,
  input  logic             cr_wr_en,
  input  logic [IDX_W-1:0] cr_wr_idx,
  input  logic [CR_W-1:0]  cr_wr_data,
  input  logic [IDX_W-1:0] cr_rd_idx,
  output logic [CR_W-1:0]  cr_rd_data,
  input  logic             flag_wr_en,
  input  logic [SEL_W-1:0] flag_sel,
  input  logic             flag_wr_val,
  input  logic [SEL_W-1:0] flag_rd_sel,
  output logic             flag_rd_val
);
  localparam int PAD_W = CR_W - SR_W;

  logic            cr0_wr;
  logic            crf_wr;
  logic            cr0_rd;
  logic            mode_wr_blocked;
  logic            flag_applied;
  sr_t             sr_value;
  logic [CR_W-1:0] crf_rd_data;

  assign cr0_wr = cr_wr_en && (cr_wr_idx == '0);
  assign crf_wr = cr_wr_en && (cr_wr_idx != '0);
  assign cr0_rd = (cr_rd_idx == '0);

  pc_mode_reg #(.PC_W(PC_W)) u_pc (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (pc_wr_en),
    .wr_data          (pc_wr_data),
    .mode_req_en      (mode_wr_en),
    .mode_req_val     (mode_wr_val),
    .pc_q             (pc_q),
    .mode_q           (mode_q),
    .mode_req_blocked (mode_wr_blocked)
  );

  status_word u_sr (
    .clk          (clk),
    .rst_n        (rst_n),
    .full_wr_en   (cr0_wr),
    .full_wr_data (cr_wr_data[SR_W-1:0]),
    .flag_wr_en   (flag_wr_en),
    .flag_sel     (flag_sel),
    .flag_wr_val  (flag_wr_val),
    .flag_rd_sel  (flag_rd_sel),
    .flag_rd_val  (flag_rd_val),
    .flag_applied (flag_applied),
    .sr_q         (sr_value)
  );

  ctrl_regfile #(.DEPTH(CR_DEPTH), .W(CR_W), .IDX_W(IDX_W)) u_crf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (crf_wr),
    .wr_idx  (cr_wr_idx),
    .wr_data (cr_wr_data),
    .rd_idx  (cr_rd_idx),
    .rd_data (crf_rd_data)
  );

  assign cr_rd_data = cr0_rd ? {{PAD_W{1'b0}}, sr_value} : crf_rd_data;
endmodule

// File: rtl/pc_ctrl_state_chk.sv
module pc_ctrl_state_chk
  import pcs_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int CR_W  = 64,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pc_wr_en,
  input logic [PC_W-1:0]  pc_wr_data,
  input logic [PC_W-1:0]  pc_q,
  input logic             mode_q,
  input logic             mode_wr_blocked,
  input logic             cr_wr_en,
  input logic [IDX_W-1:0] cr_wr_idx,
  input logic [CR_W-1:0]  cr_wr_data,
  input logic [IDX_W-1:0] cr_rd_idx,
  input logic [CR_W-1:0]  cr_rd_data,
  input logic             flag_wr_en,
  input logic [SEL_W-1:0] flag_sel,
  input logic             flag_wr_val,
  input logic             flag_applied,
  input sr_t              sr_value
);
  p_pc_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);

  p_pc_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> pc_q[PC_W-1:1] == $past(pc_wr_data[PC_W-1:1]));

  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> mode_q == $past(pc_wr_data[0]));

  p_mode_direct_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_blocked && !pc_wr_en) |=> $stable(mode_q));

  p_cr0_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_idx == '0) |-> (cr_rd_data[CR_W-1:SR_W] == '0 && cr_rd_data[SR_W-1:0] == sr_value));

  p_cr0_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && cr_wr_idx == '0) |=> sr_value == $past(cr_wr_data[SR_W-1:0]));

  p_flag_only_own_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_applied |=> ((sr_value ^ $past(sr_value)) & ~$past(flag_mask(flag_sel))) == '0);

  p_flag_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_applied |=> (|(sr_value & $past(flag_mask(flag_sel)))) == $past(flag_wr_val));

  p_cr0_beats_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && cr_wr_idx == '0 && flag_wr_en) |-> !flag_applied);

  p_invalid_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && flag_sel >= 3'd6 && !(cr_wr_en && cr_wr_idx == '0)) |=> $stable(sr_value));
endmodule

bind pc_ctrl_state pc_ctrl_state_chk #(.PC_W(PC_W), .CR_W(CR_W), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pc_wr_en        (pc_wr_en),
  .pc_wr_data      (pc_wr_data),
  .pc_q            (pc_q),
  .mode_q          (mode_q),
  .mode_wr_blocked (mode_wr_blocked),
  .cr_wr_en        (cr_wr_en),
  .cr_wr_idx       (cr_wr_idx),
  .cr_wr_data      (cr_wr_data),
  .cr_rd_idx       (cr_rd_idx),
  .cr_rd_data      (cr_rd_data),
  .flag_wr_en      (flag_wr_en),
  .flag_sel        (flag_sel),
  .flag_wr_val     (flag_wr_val),
  .flag_applied    (flag_applied),
  .sr_value        (sr_value)
);

// File: tb/pc_ctrl_state_tb.sv
`timescale 1ns/1ps
module pc_ctrl_state_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_wr_en = 0;
  logic [63:0] pc_wr_data = '0;
  logic [63:0] pc_q;
  logic        mode_q;
  logic        mode_wr_en = 0, mode_wr_val = 0;
  logic        cr_wr_en = 0;
  logic [5:0]  cr_wr_idx = '0;
  logic [63:0] cr_wr_data = '0;
  logic [5:0]  cr_rd_idx = '0;
  logic [63:0] cr_rd_data;
  logic        flag_wr_en = 0;
  logic [2:0]  flag_sel = '0;
  logic        flag_wr_val = 0;
  logic [2:0]  flag_rd_sel = '0;
  logic        flag_rd_val;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  logic [63:0] m_pc;
  logic        m_mode;
  logic [31:0] m_sr;
  logic [63:0] m_cr [64];

  always #10 clk = ~clk;

  pc_ctrl_state u_dut (
    .clk(clk), .rst_n(rst_n),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_q(pc_q), .mode_q(mode_q),
    .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
    .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx), .cr_wr_data(cr_wr_data),
    .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
    .flag_wr_en(flag_wr_en), .flag_sel(flag_sel), .flag_wr_val(flag_wr_val),
    .flag_rd_sel(flag_rd_sel), .flag_rd_val(flag_rd_val)
  );

  // status bit position for a selector code, -1 when none (R7, R12)
  function automatic int bit_of(input logic [2:0] s);
    int t [6] = '{14, 13, 12, 9, 8, 1};
    return (s < 3'd6) ? t[s] : -1;
  endfunction

  function automatic logic [63:0] exp_cr(input logic [5:0] i);
    return (i == 6'd0) ? {32'h0, m_sr} : m_cr[i];
  endfunction

  function automatic logic exp_flag(input logic [2:0] s);
    int p = bit_of(s);
    return (p < 0) ? 1'b0 : m_sr[p];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_wr();
    pc_wr_en = 0; mode_wr_en = 0; cr_wr_en = 0; flag_wr_en = 0;
  endtask

  // take one edge with the inputs now driven, then update the model
  task automatic step();
    int p;
    @(posedge clk);
    #1;
    if (pc_wr_en) begin
      m_pc   = {pc_wr_data[63:1], 1'b0};
      m_mode = pc_wr_data[0];
    end
    if (cr_wr_en) begin
      if (cr_wr_idx == 6'd0) m_sr = cr_wr_data[31:0];
      else m_cr[cr_wr_idx] = cr_wr_data;
    end
    p = bit_of(flag_sel);
    if (flag_wr_en && p >= 0 && !(cr_wr_en && cr_wr_idx == 6'd0)) m_sr[p] = flag_wr_val;
    @(negedge clk);
    clear_wr();
  endtask

  task automatic read_cr(input string tag, input logic [5:0] i);
    cr_rd_idx = i; #1;
    check(tag, cr_rd_data, exp_cr(i));
  endtask

  task automatic read_flag(input string tag, input logic [2:0] s);
    flag_rd_sel = s; #1;
    check(tag, {63'h0, flag_rd_val}, {63'h0, exp_flag(s)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    m_pc = '0; m_mode = 0; m_sr = '0;
    for (int i = 0; i < 64; i++) m_cr[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 pc", pc_q, 64'h0);
    check("R10 mode", {63'h0, mode_q}, 64'h0);
    for (int i = 0; i < 64; i++) read_cr("R10 cr", 6'(i));
    read_flag("R10 flag", 3'd0);

    // R1 R2 R11: odd PC write, invisible before the edge
    pc_wr_en = 1; pc_wr_data = 64'h8000_1234_5678_9ABF; #1;
    check("R11 pc before edge", pc_q, 64'h0);
    step();
    check("R1 pc odd", pc_q, 64'h8000_1234_5678_9ABE);
    check("R2 mode odd", {63'h0, mode_q}, 64'h1);

    // R3: direct mode requests are dropped
    mode_wr_en = 1; mode_wr_val = 0; step();
    check("R3 mode kept 1", {63'h0, mode_q}, 64'h1);
    pc_wr_en = 1; pc_wr_data = 64'h0000_0000_0000_1000; step();
    check("R2 mode even", {63'h0, mode_q}, 64'h0);
    mode_wr_en = 1; mode_wr_val = 1; step();
    check("R3 mode kept 0", {63'h0, mode_q}, 64'h0);

    // R4: top and bottom stored entries
    cr_wr_en = 1; cr_wr_idx = 6'd63; cr_wr_data = 64'hFEDC_BA98_7654_3210; step();
    cr_wr_en = 1; cr_wr_idx = 6'd1; cr_wr_data = 64'h1111_2222_3333_4444; step();
    read_cr("R4 cr63", 6'd63);
    read_cr("R4 cr1", 6'd1);
    read_cr("R4 cr2 untouched", 6'd2);

    // R5 R6: alias write drops upper half, leaves entry 1
    cr_wr_en = 1; cr_wr_idx = 6'd0; cr_wr_data = 64'hDEAD_BEEF_0000_0000; step();
    cr_rd_idx = 6'd0; #1;
    check("R6 cr0 upper dropped", cr_rd_data, 64'h0);
    cr_wr_en = 1; cr_wr_idx = 6'd0; cr_wr_data = 64'hDEAD_BEEF_1234_5678; step();
    cr_rd_idx = 6'd0; #1;
    check("R5 cr0 zero-extended", cr_rd_data, 64'h0000_0000_1234_5678);
    read_cr("R6 cr1 unchanged", 6'd1);

    // R7 R8: each flag set then cleared against a known word
    cr_wr_en = 1; cr_wr_idx = 6'd0; cr_wr_data = 64'h0; step();
    for (int s = 0; s < 6; s++) begin
      flag_wr_en = 1; flag_sel = 3'(s); flag_wr_val = 1; step();
      cr_rd_idx = 6'd0; #1;
      check("R7 flag position", cr_rd_data, 64'h1 << bit_of(3'(s)));
      read_flag("R7 flag read", 3'(s));
      flag_wr_en = 1; flag_sel = 3'(s); flag_wr_val = 0; step();
    end
    cr_wr_en = 1; cr_wr_idx = 6'd0; cr_wr_data = 64'hFFFF_FFFF; step();
    flag_wr_en = 1; flag_sel = 3'd3; flag_wr_val = 0; step();
    cr_rd_idx = 6'd0; #1;
    check("R8 clear only bit 9", cr_rd_data, 64'h0000_0000_FFFF_FDFF);

    // R9: PC and flag together; alias write beats flag write
    pc_wr_en = 1; pc_wr_data = 64'h0000_0000_0000_2001;
    flag_wr_en = 1; flag_sel = 3'd3; flag_wr_val = 1; step();
    check("R9 pc with flag", pc_q, 64'h2000);
    cr_rd_idx = 6'd0; #1;
    check("R9 flag with pc", cr_rd_data, 64'hFFFF_FFFF);
    cr_wr_en = 1; cr_wr_idx = 6'd0; cr_wr_data = 64'h0000_0000_0000_0000;
    flag_wr_en = 1; flag_sel = 3'd0; flag_wr_val = 1; step();
    cr_rd_idx = 6'd0; #1;
    check("R9 cr0 wins", cr_rd_data, 64'h0);

    // R12: unused selector codes
    flag_wr_en = 1; flag_sel = 3'd6; flag_wr_val = 1; step();
    flag_wr_en = 1; flag_sel = 3'd7; flag_wr_val = 1; step();
    cr_rd_idx = 6'd0; #1;
    check("R12 write ignored", cr_rd_data, 64'h0);
    cr_wr_en = 1; cr_wr_idx = 6'd0; cr_wr_data = 64'hFFFF_FFFF; step();
    read_flag("R12 read sel6", 3'd6);
    read_flag("R12 read sel7", 3'd7);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      pc_wr_en    = ($urandom % 4) == 0;
      d = {$urandom, $urandom};
      pc_wr_data  = d;
      mode_wr_en  = $urandom % 2;
      mode_wr_val = $urandom % 2;
      cr_wr_en    = ($urandom % 2) == 0;
      cr_wr_idx   = (($urandom % 3) == 0) ? 6'd0 : 6'($urandom);
      cr_wr_data  = {$urandom, $urandom};
      flag_wr_en  = $urandom % 2;
      flag_sel    = 3'($urandom);
      flag_wr_val = $urandom % 2;
      step();
      check("R1 pc random", pc_q, m_pc);
      check("R3 mode random", {63'h0, mode_q}, {63'h0, m_mode});
      d[5:0] = 6'($urandom);
      read_cr((d[5:0] == 6'd0) ? "R5 cr0 random" : "R4 cr random", d[5:0]);
      read_flag("R8 flag random", 3'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule